// File: doc/BRIEF.md
# Head Stepper Drive Controller

This block moves a disk drive's read/write head by a requested number of track steps. A caller supplies a one-cycle request along with a direction, a 2-bit rate code and a step count. The controller then issues the steps at the chosen spacing. After the last step it waits out a head settling interval, and then it reports completion. Working out how many steps a seek needs, checking the track number afterwards and moving any data are all handled elsewhere.

A static mode input selects one of two drive styles, and both are driven by the same timing engine. In three-phase mode, three active-low phase lines rotate one position per step, and the direction sets which way they rotate. In step/direction mode, one line carries a short step pulse and a second line carries the direction. The direction is set up a fixed lead time before the first pulse. All intervals are counted in cycles of a 2 MHz clock. They are held as parameters, so a bench or a different clock can scale them.

Top module: `head_step_ctrl`

## Requirements
- R1: After reset, `busy_o` and `done_o` are 0. In three-phase mode `motor_o` is 3'b110, meaning the first phase is active. In step/direction mode `motor_o` is 3'b100: step low, direction 0, unused line high.
- R2: The rate code latched at acceptance sets the spacing between successive steps. Codes 0, 1, 2 and 3 select `RATE0_CYC`, `RATE1_CYC`, `RATE2_CYC` and `RATE3_CYC` cycles.
- R3: In three-phase mode exactly one bit of `motor_o` is low. Bit 0 is the first phase, bit 1 the second and bit 2 the third. Each step moves the low bit. For direction 1 (inward) the order is 0→1→2→0. For direction 0 (outward) the order is 0→2→1→0.
- R4: In step/direction mode each step is a high pulse on `motor_o[0]` lasting exactly `PULSE_CYC` cycles, and `motor_o[2]` stays high.
- R5: In step/direction mode `motor_o[1]` shows the latched direction, with 1 meaning inward. It takes its new value in the cycle where `busy_o` rises and holds it while busy. The first step pulse starts exactly `LEAD_CYC` cycles later.
- R6: The number of steps issued equals the `count_i` value latched at acceptance. A count of 0 issues no step.
- R7: `done_o` pulses exactly `RATE_n + SETTLE_CYC` cycles after the last step starts. If the count is 0, `done_o` pulses `SETTLE_CYC` cycles after acceptance in three-phase mode, or `LEAD_CYC + SETTLE_CYC` cycles after acceptance in step/direction mode.
- R8: `busy_o` is high from the cycle after a request is accepted until the `done_o` cycle. `done_o` lasts one cycle, and `busy_o` falls in that same cycle.
- R9: While `busy_o` is high, `step_req_i` and changes to `dir_in_i`, `rate_i` and `count_i` have no effect on the steps, their spacing or the direction.
- R10: In three-phase mode the first step appears in the same cycle in which `busy_o` rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 2 MHz timing clock |
| rst_n | input | 1 | Synchronous active-low reset |
| mode_sd_i | input | 1 | Static mode select: 0 = three-phase drive, 1 = step/direction |
| step_req_i | input | 1 | Start a sequence; taken only when idle |
| dir_in_i | input | 1 | Step direction, 1 = inward |
| rate_i | input | 2 | Step-rate code |
| count_i | input | CNT_W | Number of steps to issue |
| motor_o | output | 3 | Phase lines, or {1, direction, step} in step/direction mode |
| busy_o | output | 1 | Sequence in progress |
| done_o | output | 1 | One-cycle end-of-settle pulse |

## Verification
The bench targets the boundaries of a sequence: a count of zero, the first step, and the step before settling. It also checks the exact spacing for every rate code. A design that stepped once on a zero count, or dropped the first or last step, would show a step total that differs from the count. A design that lost the lead time or settled one cycle short would move the first pulse or the done pulse off its computed cycle. The bench also sends requests and changes the inputs in the middle of a sequence. A controller that re-latched its inputs or restarted would change the direction line, the rotation or the spacing. It also checks the rotation in both directions, where a swapped rotation order would show up as a wrong next phase.

// File: rtl/head_step_pkg.sv
// Package: shared types and helpers for the head stepper controller.
// Assumes a three-phase index encoded 0..2.
package head_step_pkg;

    typedef enum logic [1:0] {
        SEQ_IDLE   = 2'd0,
        SEQ_LEAD   = 2'd1,
        SEQ_STEP   = 2'd2,
        SEQ_SETTLE = 2'd3
    } seq_state_t;

    // Next phase index: inward counts up, outward counts down, both modulo 3.
    function automatic logic [1:0] next_phase(input logic [1:0] cur, input logic inward);
        logic [1:0] res;
        if (inward) res = (cur == 2'd2) ? 2'd0 : cur + 2'd1;
        else        res = (cur == 2'd0) ? 2'd2 : cur - 2'd1;
        return res;
    endfunction

    // Larger of two integers, used to size counters.
    function automatic int imax(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/step_sequencer.sv
// Step sequencer: accepts a request while idle, runs an optional direction
// lead, issues `count` step events spaced by the selected rate period, then
// waits the settle interval and emits a one-cycle done.
// Assumes all cycle parameters are >= 2 and fit in TMR_W bits.
module step_sequencer
    import head_step_pkg::*;
#(
    parameter int CNT_W      = 8,
    parameter int TMR_W      = 16,
    parameter int RATE0_CYC  = 12000,
    parameter int RATE1_CYC  = 12000,
    parameter int RATE2_CYC  = 20000,
    parameter int RATE3_CYC  = 40000,
    parameter int SETTLE_CYC = 20000,
    parameter int LEAD_CYC   = 48
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sd_mode,
    input  logic             req,
    input  logic             dir_in,
    input  logic [1:0]       rate,
    input  logic [CNT_W-1:0] count,
    output logic             fire,
    output logic             fire_dir,
    output logic             dir_q,
    output logic             busy,
    output logic             done
);

    localparam logic [TMR_W-1:0] LEAD_LD   = TMR_W'(LEAD_CYC - 1);
    localparam logic [TMR_W-1:0] SETTLE_LD = TMR_W'(SETTLE_CYC - 1);

    seq_state_t       state, state_n;
    logic [TMR_W-1:0] timer, timer_n;
    logic [CNT_W-1:0] remain, remain_n;
    logic [1:0]       rate_q;
    logic [1:0]       rate_sel;
    logic [TMR_W-1:0] period_ld;
    logic             done_n;

    // Select the rate code: live input on acceptance, latched copy afterwards.
    assign rate_sel = (state == SEQ_IDLE) ? rate : rate_q;
    assign fire_dir = (state == SEQ_IDLE) ? dir_in : dir_q;

    // Map the rate code to a reload value for the step timer.
    always_comb begin
        case (rate_sel)
            2'd0:    period_ld = TMR_W'(RATE0_CYC - 1);
            2'd1:    period_ld = TMR_W'(RATE1_CYC - 1);
            2'd2:    period_ld = TMR_W'(RATE2_CYC - 1);
            default: period_ld = TMR_W'(RATE3_CYC - 1);
        endcase
    end

    // Next-state logic for the lead / step / settle sequence.
    always_comb begin
        state_n  = state;
        timer_n  = (timer != '0) ? timer - 1'b1 : timer;
        remain_n = remain;
        fire     = 1'b0;
        done_n   = 1'b0;
        case (state)
            SEQ_IDLE: begin
                if (req) begin
                    if (sd_mode) begin
                        state_n  = SEQ_LEAD;
                        timer_n  = LEAD_LD;
                        remain_n = count;
                    end else if (count == '0) begin
                        state_n  = SEQ_SETTLE;
                        timer_n  = SETTLE_LD;
                        remain_n = '0;
                    end else begin
                        fire     = 1'b1;
                        state_n  = SEQ_STEP;
                        timer_n  = period_ld;
                        remain_n = count - 1'b1;
                    end
                end
            end
            SEQ_LEAD, SEQ_STEP: begin
                if (timer == '0) begin
                    if (remain == '0) begin
                        state_n = SEQ_SETTLE;
                        timer_n = SETTLE_LD;
                    end else begin
                        fire     = 1'b1;
                        state_n  = SEQ_STEP;
                        timer_n  = period_ld;
                        remain_n = remain - 1'b1;
                    end
                end
            end
            default: begin
                if (timer == '0) begin
                    state_n = SEQ_IDLE;
                    done_n  = 1'b1;
                end
            end
        endcase
    end

    // Sequence registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state  <= SEQ_IDLE;
            timer  <= '0;
            remain <= '0;
            done   <= 1'b0;
        end else begin
            state  <= state_n;
            timer  <= timer_n;
            remain <= remain_n;
            done   <= done_n;
        end
    end

    // Latch direction and rate code at acceptance only.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dir_q  <= 1'b0;
            rate_q <= 2'd0;
        end else if (state == SEQ_IDLE && req) begin
            dir_q  <= dir_in;
            rate_q <= rate;
        end
    end

    assign busy = (state != SEQ_IDLE);

endmodule

// File: rtl/phase_rotator.sv
// Phase rotator: holds the active phase index of a three-phase motor and
// moves it one position per advance in the given direction.
// Assumes advance is a single-cycle event.
module phase_rotator
    import head_step_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       advance,
    input  logic       inward,
    output logic [1:0] phase_idx
);

    // Reset to the first phase, then rotate on each advance.
    always_ff @(posedge clk) begin
        if (!rst_n)       phase_idx <= 2'd0;
        else if (advance) phase_idx <= next_phase(phase_idx, inward);
    end

endmodule

// File: rtl/step_pulse_gen.sv
// Step pulse generator: on a trigger, drives a high pulse lasting exactly
// PULSE_CYC cycles. Assumes triggers are further apart than the pulse width.
module step_pulse_gen #(
    parameter int PULSE_CYC = 8,
    localparam int PW_W     = $clog2(PULSE_CYC + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic trigger,
    output logic pulse
);

    logic [PW_W-1:0] left;

    // Load the width on a trigger, then count down to zero.
    always_ff @(posedge clk) begin
        if (!rst_n)           left <= '0;
        else if (trigger)     left <= PW_W'(PULSE_CYC);
        else if (left != '0)  left <= left - 1'b1;
    end

    assign pulse = (left != '0);

endmodule

// File: rtl/head_step_ctrl.sv
// Head stepper controller top: joins the sequencer with either the three-phase
// rotator or the step pulse generator and muxes the drive lines by mode.
// Assumes mode_sd_i is static (changed only while in reset).
module head_step_ctrl
    import head_step_pkg::*;
#(
    parameter int CNT_W      = 8,
    parameter int RATE0_CYC  = 12000,
    parameter int RATE1_CYC  = 12000,
    parameter int RATE2_CYC  = 20000,
    parameter int RATE3_CYC  = 40000,
    parameter int SETTLE_CYC = 20000,
    parameter int PULSE_CYC  = 8,
    parameter int LEAD_CYC   = 48
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             mode_sd_i,
    input  logic             step_req_i,
    input  logic             dir_in_i,
    input  logic [1:0]       rate_i,
    input  logic [CNT_W-1:0] count_i,
    output logic [2:0]       motor_o,
    output logic             busy_o,
    output logic             done_o
);

    localparam int MAX_RATE = imax(imax(RATE0_CYC, RATE1_CYC), imax(RATE2_CYC, RATE3_CYC));
    localparam int MAX_CYC  = imax(MAX_RATE, imax(SETTLE_CYC, LEAD_CYC));
    localparam int TMR_W    = $clog2(MAX_CYC + 1);
    localparam int N_PHASE  = 3;

    logic       fire, fire_dir, dir_q;
    logic [1:0] phase_idx;
    logic       step_pulse;
    logic [N_PHASE-1:0] phase_n;

    step_sequencer #(
        .CNT_W(CNT_W), .TMR_W(TMR_W),
        .RATE0_CYC(RATE0_CYC), .RATE1_CYC(RATE1_CYC),
        .RATE2_CYC(RATE2_CYC), .RATE3_CYC(RATE3_CYC),
        .SETTLE_CYC(SETTLE_CYC), .LEAD_CYC(LEAD_CYC)
    ) u_seq (
        .clk(clk), .rst_n(rst_n), .sd_mode(mode_sd_i), .req(step_req_i),
        .dir_in(dir_in_i), .rate(rate_i), .count(count_i),
        .fire(fire), .fire_dir(fire_dir), .dir_q(dir_q),
        .busy(busy_o), .done(done_o)
    );

    phase_rotator u_rot (
        .clk(clk), .rst_n(rst_n), .advance(fire && !mode_sd_i),
        .inward(fire_dir), .phase_idx(phase_idx)
    );

    step_pulse_gen #(.PULSE_CYC(PULSE_CYC)) u_pulse (
        .clk(clk), .rst_n(rst_n), .trigger(fire && mode_sd_i), .pulse(step_pulse)
    );

    // Active-low phase decode, one line per phase.
    for (genvar g = 0; g < N_PHASE; g++) begin : g_phase
        assign phase_n[g] = (phase_idx != 2'(g));
    end

    // Route drive lines according to the selected motor interface.
    always_comb begin
        if (mode_sd_i) motor_o = {1'b1, dir_q, step_pulse};
        else           motor_o = phase_n;
    end

endmodule

// File: rtl/head_step_ctrl_chk.sv
// Checker for head_step_ctrl: port-level temporal properties, bound below.
module head_step_ctrl_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       mode_sd_i,
    input logic       step_req_i,
    input logic [2:0] motor_o,
    input logic       busy_o,
    input logic       done_o
);

    AST_DONE_ENDS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (!busy_o && $past(busy_o)));                                  // R8
    AST_BUSY_FALL_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy_o) |-> done_o);                                               // R8
    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);                                                     // R8
    AST_PHASE_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        !mode_sd_i |-> ($countones(~motor_o) == 1));                             // R3
    AST_SD_SPARE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        mode_sd_i |-> motor_o[2]);                                               // R4
    AST_DIR_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_sd_i && busy_o && $past(busy_o)) |-> $stable(motor_o[1]));         // R5
    AST_PHASE_MOVE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        (!mode_sd_i && !$stable(motor_o)) |-> busy_o);                           // R6
    AST_PULSE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_sd_i && $rose(motor_o[0])) |-> busy_o);                            // R6

endmodule

bind head_step_ctrl head_step_ctrl_chk u_chk (
    .clk(clk), .rst_n(rst_n), .mode_sd_i(mode_sd_i), .step_req_i(step_req_i),
    .motor_o(motor_o), .busy_o(busy_o), .done_o(done_o)
);

// File: tb/head_step_ctrl_tb.sv
module head_step_ctrl_tb;

    localparam int CLK_PERIOD = 10;
    localparam int CNT_W  = 8;
    localparam int R0 = 30, R1 = 40, R2 = 55, R3 = 70;
    localparam int SETTLE = 25, PULSE = 3, LEAD = 7;
    localparam int LIMIT  = 900;

    logic clk = 1'b0, rst_n = 1'b0, mode_sd = 1'b0, req = 1'b0, dir_i = 1'b0;
    logic [1:0] rate_i = 2'd0;
    logic [CNT_W-1:0] count_i = '0;
    logic [2:0] motor_o;
    logic busy_o, done_o;

    int n_chk = 0, n_bad = 0;
    bit summary_done = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    head_step_ctrl #(
        .CNT_W(CNT_W), .RATE0_CYC(R0), .RATE1_CYC(R1), .RATE2_CYC(R2),
        .RATE3_CYC(R3), .SETTLE_CYC(SETTLE), .PULSE_CYC(PULSE), .LEAD_CYC(LEAD)
    ) u_dut (
        .clk(clk), .rst_n(rst_n), .mode_sd_i(mode_sd), .step_req_i(req),
        .dir_in_i(dir_i), .rate_i(rate_i), .count_i(count_i),
        .motor_o(motor_o), .busy_o(busy_o), .done_o(done_o)
    );

    function automatic int period_of(input logic [1:0] r);
        case (r)
            2'd0: return R0;
            2'd1: return R1;
            2'd2: return R2;
            default: return R3;
        endcase
    endfunction

    function automatic int idx_of(input logic [2:0] m);
        case (m)
            3'b110: return 0;
            3'b101: return 1;
            3'b011: return 2;
            default: return -1;
        endcase
    endfunction

    function automatic int step_idx(input int cur, input bit inward);
        if (inward) return (cur + 1) % 3;
        return (cur + 2) % 3;
    endfunction

    task automatic chk(input bit ok, input string rq, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", rq, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!summary_done) begin
            summary_done = 1;
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        end
        $finish;
    endtask

    // Reset with a given mode and check the idle outputs (R1).
    task automatic do_reset(input bit sd);
        @(negedge clk);
        rst_n = 1'b0; mode_sd = sd; req = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(busy_o == 1'b0, "R1 busy", busy_o, 0);
        chk(done_o == 1'b0, "R1 done", done_o, 0);
        chk(motor_o == (sd ? 3'b100 : 3'b110), "R1 motor", motor_o, sd ? 3'b100 : 3'b110);
    endtask

    // Issue one sequence and check every step, the settle and busy/done.
    task automatic run_seq(input bit dir, input logic [1:0] rate, input int cnt, input bit poke);
        logic [2:0] prev;
        int steps = 0, last = -1, rise = -1, done_at = -1;
        int per = period_of(rate);
        int exp_done;
        bit fin = 0;
        bit sd = mode_sd;
        prev = motor_o;
        req = 1'b1; dir_i = dir; rate_i = rate; count_i = CNT_W'(cnt);
        @(negedge clk);
        req = 1'b0; dir_i = ~dir; rate_i = rate + 2'd1; count_i = CNT_W'(cnt + 3);
        chk(busy_o == 1'b1, "R8 busy rise", busy_o, 1);
        for (int c = 0; c < LIMIT && !fin; c++) begin
            if (c > 0) @(negedge clk);
            if (poke && c == 3) begin req = 1'b1; dir_i = ~dir; rate_i = ~rate; end
            if (poke && c == 4) req = 1'b0;
            if (!sd) begin
                if (motor_o != prev) begin
                    chk(idx_of(motor_o) == step_idx(idx_of(prev), dir), "R3 phase order",
                        idx_of(motor_o), step_idx(idx_of(prev), dir));
                    if (steps == 0) chk(c == 0, "R10 first step", c, 0);
                    else chk(c - last == per, "R2 spacing", c - last, per);
                    last = c; steps++;
                end
            end else begin
                if (motor_o[1] != dir || motor_o[2] != 1'b1) begin
                    chk(0, "R5 direction line", motor_o[1], dir);
                end
                if (motor_o[0] && !prev[0]) begin
                    if (steps == 0) chk(c == LEAD, "R5 lead", c, LEAD);
                    else chk(c - last == per, "R2 spacing", c - last, per);
                    last = c; rise = c; steps++;
                end
                if (!motor_o[0] && prev[0])
                    chk(c - rise == PULSE, "R4 pulse width", c - rise, PULSE);
            end
            if (done_o) begin
                fin = 1; done_at = c;
                chk(busy_o == 1'b0, "R8 busy at done", busy_o, 0);
            end else if (!busy_o) begin
                chk(0, "R8 busy early drop", c, -1);
                fin = 1;
            end
            prev = motor_o;
        end
        chk(steps == cnt, poke ? "R9 steps with extra request" : "R6 step count", steps, cnt);
        if (cnt > 0) exp_done = last + per + SETTLE;
        else         exp_done = sd ? LEAD + SETTLE : SETTLE;
        chk(done_at == exp_done, "R7 settle to done", done_at, exp_done);
        @(negedge clk);
        chk(done_o == 1'b0, "R8 done one cycle", done_o, 0);
        chk(busy_o == 1'b0, "R8 idle after done", busy_o, 0);
    endtask

    initial begin
        void'($urandom(32'd4242));
        // Directed: three-phase mode.
        do_reset(1'b0);
        run_seq(1'b1, 2'd0, 4, 0);          // inward, rate 0
        run_seq(1'b0, 2'd3, 4, 0);          // outward, rate 3
        run_seq(1'b1, 2'd1, 0, 0);          // zero count
        run_seq(1'b0, 2'd2, 1, 1);          // single step with extra request
        // Directed: step/direction mode.
        do_reset(1'b1);
        run_seq(1'b1, 2'd2, 3, 0);
        run_seq(1'b0, 2'd1, 2, 1);
        run_seq(1'b1, 2'd0, 0, 0);
        // Random mix over both modes.
        for (int m = 0; m < 2; m++) begin
            do_reset(m[0]);
            for (int k = 0; k < 10; k++) begin
                run_seq(1'($urandom), 2'($urandom), int'($urandom % 6), 1'($urandom));
                repeat (int'($urandom % 4)) @(negedge clk);
            end
        end
        finish_run();
    end

    initial begin
        repeat (150000) @(posedge clk);
        chk(0, "watchdog", 0, 1);
        finish_run();
    end

endmodule